// File: doc/BRIEF.md
# Two-Channel Power-Down and Mute Controller

This block is the control-register slice of a two-channel converter front end. Each channel has a gain stage (PGA) and a converter stage (ADC). A byte-wide register bus reaches two registers: a fixed identification byte and a power control byte. From the power control byte the block derives, for each of the four stages, a registered power-enable and a registered mute.

A stage's power-down request does not always mean the same thing. If the request is raised while the front end is fully up, the stage is only muted and stays powered. A stage is really switched off only when its request is already set while the whole front end is down, and then the front end is brought back up. Software therefore turns off single stages in three writes: assert the global power-down, set the wanted stage bits, then clear the global power-down.

A two-state machine tracks the front end. In `PS_DOWN` every stage is unpowered. In `PS_UP` the front end is up. The transition `GO_DOWN` (from `PS_UP` to `PS_DOWN`) fires when the new register value has the global bit set or all four stage bits set. The transition `WAKE` (from `PS_DOWN` to `PS_UP`) fires when the new value has neither. Each stage latches a hard-off flag on `WAKE`, taken from its own request bit, and holds that flag until the next `GO_DOWN`.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: After reset the control register reads 0x61 at address 0x02: global power-down set, all stage bits clear, reserved bits 6:5 high. All enables and mutes are 0 and the state is `PS_DOWN`.
- R2: Address 0x01 always reads 0xD9. That is identifier 11011 in bits 7:3 and revision 001 in bits 2:0. Writes to 0x01 change no register and no output.
- R3: Control layout at 0x02: bit 0 global power-down, bit 1 ADC A, bit 2 ADC B, bit 3 PGA A, bit 4 PGA B. Bits 4:0 store what is written. Bits 7:5 always read 011, whatever value is written to them.
- R4: Reads of any address other than 0x01 and 0x02 return 0x00. Writes there change no register and no output.
- R5: If the global bit is set, or all four stage bits are set, every enable and every mute is 0.
- R6: In `PS_UP`, setting a stage bit that was not latched hard-off raises that stage's mute and keeps its enable at 1.
- R7: In `PS_UP`, clearing a stage bit removes that stage's mute.
- R8: On `WAKE`, each stage whose bit is set is hard-off (enable 0, mute 0). Every other stage gets enable 1.
- R9: A hard-off stage stays off while its bit is cleared in `PS_UP`. It powers up only after a `GO_DOWN` followed by a `WAKE` with its bit clear.
- R10: Enables and mutes change at the clock edge that accepts the write causing the change. Without a write they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| adc_en | output | 2 | ADC power-enable, bit 0 channel A, bit 1 channel B |
| pga_en | output | 2 | PGA power-enable, bit 0 channel A, bit 1 channel B |
| adc_mute | output | 2 | ADC mute, bit 0 channel A, bit 1 channel B |
| pga_mute | output | 2 | PGA mute, bit 0 channel A, bit 1 channel B |

## Verification
Read data is combinational from the stored registers. After a write it therefore reflects the new value as soon as the accepting edge has passed. Enables and mutes come from the write-merged register value through one flop stage, so they are due at that same edge. The bench drives each write on a falling edge and checks outputs and read-back at the next falling edge, half a period after the edge that accepted the write. Hold behaviour is checked by leaving writes idle, or by writing to ignored addresses, and confirming the outputs are unchanged one cycle later.

// File: rtl/chan_pwr_pkg.sv
package chan_pwr_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int NUM_CH    = 2;
    localparam int NUM_UNITS = 2 * NUM_CH;          // ADC and PGA per channel
    localparam int RSV_W     = DATA_W - 1 - NUM_UNITS;

    localparam logic [ADDR_W-1:0] ADDR_IDENT = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h02;

    localparam logic [4:0] IDENT_CODE = 5'b11011;
    localparam logic [2:0] REV_CODE   = 3'b001;

    localparam logic [RSV_W-1:0]     RSV_FIXED  = 3'b011;
    localparam logic [NUM_UNITS:0]   CTRL_RESET = 5'b00001; // global down, stages clear

    typedef enum logic {
        PS_DOWN = 1'b0,
        PS_UP   = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/chan_pwr_regs.sv
module chan_pwr_regs
    import chan_pwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 gdown_nxt,
    output logic [NUM_UNITS-1:0] req_nxt
);
    logic [NUM_UNITS:0] ctrl_q;
    logic [NUM_UNITS:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && reg_addr == ADDR_CTRL)
            ctrl_d = reg_wdata[NUM_UNITS:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign gdown_nxt = ctrl_d[0];
    assign req_nxt   = ctrl_d[NUM_UNITS:1];

    always_comb begin
        unique case (reg_addr)
            ADDR_IDENT: reg_rdata = {IDENT_CODE, REV_CODE};
            ADDR_CTRL:  reg_rdata = {RSV_FIXED, ctrl_q};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chan_pwr_fsm.sv
module chan_pwr_fsm
    import chan_pwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gdown_nxt,
    input  logic [NUM_UNITS-1:0] req_nxt,
    output logic                 down_nxt,
    output logic                 wake
);
    pwr_state_e state_q;
    pwr_state_e state_d;
    logic       all_down;

    assign all_down = gdown_nxt || (&req_nxt);

    // next-state decode
    always_comb begin
        unique case (state_q)
            PS_UP:   state_d = all_down ? PS_DOWN : PS_UP;   // GO_DOWN
            PS_DOWN: state_d = all_down ? PS_DOWN : PS_UP;   // WAKE
            default: state_d = PS_DOWN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_DOWN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        down_nxt = 1'b0;
        wake     = 1'b0;
        unique case (state_q)
            PS_UP:   down_nxt = (state_d == PS_DOWN);
            PS_DOWN: begin
                down_nxt = (state_d == PS_DOWN);
                wake     = (state_d == PS_UP);
            end
            default: down_nxt = 1'b1;
        endcase
    end
endmodule

// File: rtl/chan_pwr_unit.sv
module chan_pwr_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic down_nxt,
    input  logic wake,
    input  logic req,
    output logic en,
    output logic mute
);
    logic off_q;
    logic off_d;

    assign off_d = (down_nxt || wake) ? req : off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= 1'b0;
            en    <= 1'b0;
            mute  <= 1'b0;
        end else begin
            off_q <= off_d;
            en    <= !down_nxt && !off_d;
            mute  <= !down_nxt && !off_d && req;
        end
    end
endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl
    import chan_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        adc_en,
    output logic [1:0]        pga_en,
    output logic [1:0]        adc_mute,
    output logic [1:0]        pga_mute
);
    logic                 gdown_nxt;
    logic [NUM_UNITS-1:0] req_nxt;
    logic                 down_nxt;
    logic                 wake;
    logic [NUM_UNITS-1:0] unit_en;
    logic [NUM_UNITS-1:0] unit_mute;

    chan_pwr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gdown_nxt (gdown_nxt),
        .req_nxt   (req_nxt)
    );

    chan_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gdown_nxt (gdown_nxt),
        .req_nxt   (req_nxt),
        .down_nxt  (down_nxt),
        .wake      (wake)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        chan_pwr_unit u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .down_nxt (down_nxt),
            .wake     (wake),
            .req      (req_nxt[u]),
            .en       (unit_en[u]),
            .mute     (unit_mute[u])
        );
    end

    // unit order: ADC A, ADC B, PGA A, PGA B
    assign adc_en   = unit_en[NUM_CH-1:0];
    assign pga_en   = unit_en[NUM_UNITS-1:NUM_CH];
    assign adc_mute = unit_mute[NUM_CH-1:0];
    assign pga_mute = unit_mute[NUM_UNITS-1:NUM_CH];
endmodule

// File: rtl/chan_pwr_chk.sv
module chan_pwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [1:0] adc_en,
    input logic [1:0] pga_en,
    input logic [1:0] adc_mute,
    input logic [1:0] pga_mute
);
    // R2
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h01) |-> (reg_rdata == 8'hD9));

    // R3
    rsv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h02) |-> (reg_rdata[7:5] == 3'b011));

    // R4
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 8'h01 && reg_addr != 8'h02) |-> (reg_rdata == 8'h00));

    // R5
    global_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h02 && reg_wdata[0])
        |=> (adc_en == 2'b00 && pga_en == 2'b00 && adc_mute == 2'b00 && pga_mute == 2'b00));

    // R6
    mute_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((adc_mute & ~adc_en) == 2'b00) && ((pga_mute & ~pga_en) == 2'b00));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(adc_en) && $stable(pga_en) && $stable(adc_mute) && $stable(pga_mute)));
endmodule

bind chan_pwr_ctrl chan_pwr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .adc_en    (adc_en),
    .pga_en    (pga_en),
    .adc_mute  (adc_mute),
    .pga_mute  (pga_mute)
);

// File: tb/chan_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module chan_pwr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] adc_en, pga_en, adc_mute, pga_mute;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] ctrl_model = 8'h61;

    always #4 clk = ~clk;   // 125 MHz

    chan_pwr_ctrl u_chan_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_en(adc_en),
        .pga_en(pga_en), .adc_mute(adc_mute), .pga_mute(pga_mute)
    );

    // {addr, wdata, adc_en, pga_en, adc_mute, pga_mute}
    localparam int NVEC = 14;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h02, 8'h60, 2'b11, 2'b11, 2'b00, 2'b00},   // R8 wake, nothing off
        {8'h02, 8'h62, 2'b11, 2'b11, 2'b01, 2'b00},   // R6 ADC A muted only
        {8'h02, 8'h60, 2'b11, 2'b11, 2'b00, 2'b00},   // R7 mute removed
        {8'h02, 8'h7E, 2'b00, 2'b00, 2'b00, 2'b00},   // R5 all four stage bits
        {8'h02, 8'h60, 2'b11, 2'b11, 2'b00, 2'b00},   // R8 wake
        {8'h02, 8'h61, 2'b00, 2'b00, 2'b00, 2'b00},   // R5 global down
        {8'h02, 8'h69, 2'b00, 2'b00, 2'b00, 2'b00},   // R5 still down, PGA A chosen
        {8'h02, 8'h68, 2'b11, 2'b10, 2'b00, 2'b00},   // R8 PGA A hard-off
        {8'h02, 8'h60, 2'b11, 2'b10, 2'b00, 2'b00},   // R9 stays off
        {8'h02, 8'h70, 2'b11, 2'b10, 2'b00, 2'b10},   // R6 PGA B muted
        {8'h02, 8'h61, 2'b00, 2'b00, 2'b00, 2'b00},   // R5 down
        {8'h02, 8'h60, 2'b11, 2'b11, 2'b00, 2'b00},   // R9 PGA A back on
        {8'h01, 8'h00, 2'b11, 2'b11, 2'b00, 2'b00},   // R2 write to ident ignored
        {8'h05, 8'hFF, 2'b11, 2'b11, 2'b00, 2'b00}    // R4 unmapped write ignored
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [7:0] exp);
        check8(req, {adc_en, pga_en, adc_mute, pga_mute}, exp);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h02) ctrl_model = {3'b011, d[4:0]};
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check8(req, reg_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 reset outputs", 8'h00);
        read_check("R1 reset ctrl", 8'h02, 8'h61);
        read_check("R2 ident", 8'h01, 8'hD9);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][23:16], VEC[i][15:8]);
            check_outs($sformatf("vector %0d R5 R6 R7 R8 R9 R10", i), VEC[i][7:0]);
            read_check("R3 ctrl readback", 8'h02, ctrl_model);
        end

        // R2 ident unchanged after write attempt
        read_check("R2 ident after write", 8'h01, 8'hD9);
        // R4 unmapped reads
        read_check("R4 unmapped 0x00", 8'h00, 8'h00);
        read_check("R4 unmapped 0x05", 8'h05, 8'h00);
        read_check("R4 unmapped 0xFF", 8'hFF, 8'h00);

        // R3 reserved bits forced, stage bits stored
        do_write(8'h02, 8'h9F);
        read_check("R3 reserved forced", 8'h02, 8'h7F);
        check_outs("R5 all bits down", 8'h00);

        // R10 idle hold
        do_write(8'h02, 8'h64);       // wake with ADC B hard-off
        check_outs("R8 ADC B off", {2'b01, 2'b11, 2'b00, 2'b00});
        repeat (3) @(negedge clk);
        check_outs("R10 idle hold", {2'b01, 2'b11, 2'b00, 2'b00});

        // R1 reset returns defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 reset again outputs", 8'h00);
        read_check("R1 reset again ctrl", 8'h02, 8'h61);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule